// File: doc/BRIEF.md
# Branch Condition Resolution Unit

This block settles the outcome of a conditional branch in a 32-bit RISC core. Given the instruction word, the condition register, the count register and the current program address, it decodes the 5-bit options field and the 5-bit condition-bit selector. From them it decides whether the count register steps down and whether the branch is taken. It also produces the next count value with its write strobe, the link-register request with its return address, the static prediction hint, and the target address.

The options field packs several behaviours into one code. Counting can be on or off, with a zero or non-zero test on the new count. A test on one condition bit can be on or off, against a set or a clear value. All of the tests can be bypassed to give an always-taken code. The target is either the program address plus a sign-extended relative displacement, or the count register for the register-indirect form. That form cannot also decrement the count, so such a combination is flagged as invalid and suppressed. The block is purely combinational, and its results are qualified by a valid strobe.

Top module: `branch_resolve`

## Requirements
- R1: The options code is taken from instruction bits 25..21 and the selector from bits 20..16. The link request is bit 0. The 14-bit displacement is bits 15..2.
- R2: Selector value n tests condition-register bit CR[31-n]. Selector bits 4..2 name the 4-bit field and bits 1..0 name LT, GT, EQ or SO within it.
- R3: When options bit 2 is 0 the count decrements: the write strobe is 1 and the next count is the count minus 1, so 0 wraps to 0xFFFFFFFF. When options bit 2 is 1 the write strobe is 0.
- R4: For a decrementing code, options bit 1 = 1 requires the new count to be zero and bit 1 = 0 requires it to be non-zero. Non-decrementing codes ignore the count.
- R5: When options bit 4 is 0, the taken result requires the selected condition bit to equal options bit 3. When options bit 4 is 1, the condition bit is ignored. Code 1z1zz is therefore always taken.
- R6: The hint output equals options bit 0 (1 means expect taken). It never changes the taken result.
- R7: The link write strobe equals the instruction link bit, and the return address is the program address plus 4, whether or not the branch is taken.
- R8: In the relative form the target is the program address plus the sign-extended displacement shifted left by 2. In the register-indirect form the target is the incoming count with its low two bits cleared.
- R9: In the register-indirect form a decrementing code (options bit 2 = 0) raises the invalid-form output. When that happens, taken and the count write strobe are 0.
- R10: With valid low, taken, the count write strobe, the link write strobe, the hint and the invalid-form output are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | Instruction present this cycle |
| indirect_i | input | 1 | 1 selects the count-register target form |
| insn_i | input | 32 | Branch instruction word |
| cr_i | input | 32 | Condition register |
| ctr_i | input | 32 | Count register |
| pc_i | input | 32 | Address of the branch |
| taken_o | output | 1 | Branch is taken |
| target_o | output | 32 | Branch target address |
| ctr_next_o | output | 32 | Decremented count value |
| ctr_we_o | output | 1 | Write ctr_next_o to the count register |
| lr_we_o | output | 1 | Write lr_val_o to the link register |
| lr_val_o | output | 32 | Return address |
| hint_o | output | 1 | Static prediction hint |
| bad_form_o | output | 1 | Decrement requested in the register-indirect form |

## Verification
There are no registers between inputs and outputs, so every result is due in the same cycle the stimulus is applied. The bench changes inputs on the falling clock edge and samples all outputs 1 ns later, well before the next rising edge. A stale or combinationally wrong value is therefore seen without depending on edge ordering. Every 5-bit options value is crossed with the four low selector values, counts of 0, 1 and 2, and both target forms. Random words and directed mnemonic cases follow.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int XLEN   = 32;
  localparam int OPT_W  = 5;
  localparam int SEL_W  = 5;
  localparam int DISP_W = 14;

  localparam int OPT_LSB  = 21;
  localparam int SEL_LSB  = 16;
  localparam int DISP_LSB = 2;
  localparam int LINK_BIT = 0;

  localparam int STEP = 4;

  typedef struct packed {
    logic no_dec;     // count is left alone
    logic want_zero;  // new count must be zero
    logic no_cond;    // condition bit is ignored
    logic sense;      // required value of condition bit
    logic hint;
  } opt_t;
endpackage

// File: rtl/bru_opt_decode.sv
module bru_opt_decode
  import bru_pkg::*;
(
  input  logic [OPT_W-1:0] code_i,
  output opt_t             opt_o
);
  always_comb begin
    opt_o.no_cond   = code_i[4];
    opt_o.sense     = code_i[3];
    opt_o.no_dec    = code_i[2];
    opt_o.want_zero = code_i[1];
    opt_o.hint      = code_i[0];
  end
endmodule

// File: rtl/bru_cr_select.sv
module bru_cr_select
  import bru_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int SW = SEL_W
) (
  input  logic [W-1:0]  cr_i,
  input  logic [SW-1:0] sel_i,
  output logic          bit_o
);
  localparam int TOP = W - 1;
  logic [W-1:0] msb_first;

  // bit n of msb_first is CR[TOP-n]
  for (genvar g = 0; g < W; g++) begin : g_rev
    assign msb_first[g] = cr_i[TOP-g];
  end

  assign bit_o = msb_first[sel_i];
endmodule

// File: rtl/bru_count_step.sv
module bru_count_step
  import bru_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] ctr_i,
  output logic [W-1:0] ctr_dec_o,
  output logic         dec_zero_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    ctr_dec_o  = ctr_i - ONE;
    dec_zero_o = (ctr_i == ONE);
  end
endmodule

// File: rtl/bru_target.sv
module bru_target
  import bru_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int DW = DISP_W
) (
  input  logic          indirect_i,
  input  logic [DW-1:0] disp_i,
  input  logic [W-1:0]  pc_i,
  input  logic [W-1:0]  ctr_i,
  output logic [W-1:0]  target_o,
  output logic [W-1:0]  ret_o
);
  localparam int EXT = W - DW - 2;
  localparam logic [W-1:0] STEP_V = W'(STEP);

  logic [W-1:0] offset;
  logic [W-1:0] rel_tgt;

  always_comb begin
    offset   = {{EXT{disp_i[DW-1]}}, disp_i, 2'b00};
    rel_tgt  = pc_i + offset;
    target_o = indirect_i ? {ctr_i[W-1:2], 2'b00} : rel_tgt;
    ret_o    = pc_i + STEP_V;
  end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import bru_pkg::*;
(
  input  logic            valid_i,
  input  logic            indirect_i,
  input  logic [XLEN-1:0] insn_i,
  input  logic [XLEN-1:0] cr_i,
  input  logic [XLEN-1:0] ctr_i,
  input  logic [XLEN-1:0] pc_i,
  output logic            taken_o,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] ctr_next_o,
  output logic            ctr_we_o,
  output logic            lr_we_o,
  output logic [XLEN-1:0] lr_val_o,
  output logic            hint_o,
  output logic            bad_form_o
);
  logic [OPT_W-1:0]  code;
  logic [SEL_W-1:0]  sel;
  logic [DISP_W-1:0] disp;
  opt_t              opt;
  logic              cbit;
  logic              dec_zero;
  logic              cnt_ok;
  logic              cond_ok;
  logic              bad;

  assign code = insn_i[OPT_LSB  +: OPT_W];
  assign sel  = insn_i[SEL_LSB  +: SEL_W];
  assign disp = insn_i[DISP_LSB +: DISP_W];

  bru_opt_decode u_dec (
    .code_i (code),
    .opt_o  (opt)
  );

  bru_cr_select #(.W(XLEN), .SW(SEL_W)) u_sel (
    .cr_i  (cr_i),
    .sel_i (sel),
    .bit_o (cbit)
  );

  bru_count_step #(.W(XLEN)) u_cnt (
    .ctr_i      (ctr_i),
    .ctr_dec_o  (ctr_next_o),
    .dec_zero_o (dec_zero)
  );

  bru_target #(.W(XLEN), .DW(DISP_W)) u_tgt (
    .indirect_i (indirect_i),
    .disp_i     (disp),
    .pc_i       (pc_i),
    .ctr_i      (ctr_i),
    .target_o   (target_o),
    .ret_o      (lr_val_o)
  );

  always_comb begin
    bad        = indirect_i & ~opt.no_dec;
    cnt_ok     = opt.no_dec | (dec_zero == opt.want_zero);
    cond_ok    = opt.no_cond | (cbit == opt.sense);
    taken_o    = valid_i & ~bad & cnt_ok & cond_ok;
    ctr_we_o   = valid_i & ~bad & ~opt.no_dec;
    bad_form_o = valid_i & bad;
    lr_we_o    = valid_i & insn_i[LINK_BIT];
    hint_o     = valid_i & opt.hint;
  end
endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk
  import bru_pkg::*;
(
  input logic            valid_i,
  input logic            indirect_i,
  input logic [XLEN-1:0] insn_i,
  input logic [XLEN-1:0] ctr_i,
  input logic            taken_o,
  input logic [XLEN-1:0] ctr_next_o,
  input logic            ctr_we_o,
  input logic            lr_we_o,
  input logic            hint_o,
  input logic            bad_form_o
);
  always_comb begin
    // R9
    bad_form_chk: assert (!bad_form_o || (!taken_o && !ctr_we_o));
    // R10
    idle_chk: assert (valid_i || !(taken_o || ctr_we_o || lr_we_o || hint_o || bad_form_o));
    // R3
    wrap_chk: assert (!(ctr_we_o && ctr_i == '0) || ctr_next_o == '1);
    // R4
    zero_test_chk: assert (!(taken_o && !insn_i[23] && insn_i[22]) || ctr_next_o == '0);
    // R9
    indirect_dec_chk: assert (!(valid_i && indirect_i && !insn_i[23]) || bad_form_o);
    // R5
    always_chk: assert (!(valid_i && !indirect_i && insn_i[25] && insn_i[23]) || taken_o);
  end
endmodule

bind branch_resolve branch_resolve_chk u_chk (
  .valid_i    (valid_i),
  .indirect_i (indirect_i),
  .insn_i     (insn_i),
  .ctr_i      (ctr_i),
  .taken_o    (taken_o),
  .ctr_next_o (ctr_next_o),
  .ctr_we_o   (ctr_we_o),
  .lr_we_o    (lr_we_o),
  .hint_o     (hint_o),
  .bad_form_o (bad_form_o)
);

// File: tb/sim_branch_resolve.sv
`timescale 1ns/1ps
module sim_branch_resolve;
  logic clk;
  logic rst_n;
  logic        valid_i, indirect_i;
  logic [31:0] insn_i, cr_i, ctr_i, pc_i;
  logic        taken_o, ctr_we_o, lr_we_o, hint_o, bad_form_o;
  logic [31:0] target_o, ctr_next_o, lr_val_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  branch_resolve u0 (
    .valid_i(valid_i), .indirect_i(indirect_i), .insn_i(insn_i),
    .cr_i(cr_i), .ctr_i(ctr_i), .pc_i(pc_i),
    .taken_o(taken_o), .target_o(target_o), .ctr_next_o(ctr_next_o),
    .ctr_we_o(ctr_we_o), .lr_we_o(lr_we_o), .lr_val_o(lr_val_o),
    .hint_o(hint_o), .bad_form_o(bad_form_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h insn=%08h cr=%08h ctr=%08h ind=%0b",
               req, act, exp, insn_i, cr_i, ctr_i, indirect_i);
    end
  endtask

  // Expected values from the requirements
  function automatic logic exp_taken(logic v, logic ind, logic [31:0] ins, logic [31:0] cr, logic [31:0] ctr);
    logic [4:0] bo = ins[25:21];
    logic [4:0] bi = ins[20:16];
    logic cb = cr[31 - bi];
    logic nz = (ctr - 32'd1) != 0;
    logic cnt_ok, cond_ok;
    if (!v) return 1'b0;
    if (ind && !bo[2]) return 1'b0;
    cnt_ok  = bo[2] ? 1'b1 : (bo[1] ? !nz : nz);
    cond_ok = bo[4] ? 1'b1 : (cb == bo[3]);
    return cnt_ok && cond_ok;
  endfunction

  task automatic apply_and_check(input logic v, input logic ind, input logic [31:0] ins,
                                 input logic [31:0] cr, input logic [31:0] ctr, input logic [31:0] pc);
    logic dec;
    logic [31:0] tgt;
    @(negedge clk);
    valid_i = v; indirect_i = ind; insn_i = ins; cr_i = cr; ctr_i = ctr; pc_i = pc;
    #1;
    dec = v && !ins[23] && !ind;
    tgt = ind ? {ctr[31:2], 2'b00} : pc + {{16{ins[15]}}, ins[15:2], 2'b00};
    chk("R4/R5 taken", {31'd0, taken_o}, {31'd0, exp_taken(v, ind, ins, cr, ctr)});
    chk("R3 ctr_we", {31'd0, ctr_we_o}, {31'd0, dec});
    if (dec) chk("R3 ctr_next", ctr_next_o, ctr - 32'd1);
    chk("R9 bad_form", {31'd0, bad_form_o}, {31'd0, v && ind && !ins[23]});
    chk("R6 hint", {31'd0, hint_o}, {31'd0, v && ins[21]});
    chk("R7 lr_we", {31'd0, lr_we_o}, {31'd0, v && ins[0]});
    if (v && ins[0]) chk("R7 lr_val", lr_val_o, pc + 32'd4);
    if (v) chk("R8 target", target_o, tgt);
  endtask

  function automatic logic [31:0] mk(logic [4:0] bo, logic [4:0] bi, logic [13:0] bd, logic lk);
    return {6'b010000, bo, bi, bd, 1'b0, lk};
  endfunction

  initial begin
    logic [31:0] ins;
    valid_i = 0; indirect_i = 0; insn_i = 0; cr_i = 0; ctr_i = 0; pc_i = 0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // R10: idle state with an instruction that would otherwise act
    apply_and_check(1'b0, 1'b0, mk(5'b10100, 5'd0, 14'd4, 1'b1), 32'hFFFF_FFFF, 32'd1, 32'h100);
    chk("R10 idle taken", {31'd0, taken_o}, 32'd0);

    // R1 R2 R3 R4 R5 R9: exhaustive options x low selector x counts x form
    for (int bo = 0; bo < 32; bo++)
      for (int bi = 0; bi < 4; bi++)
        for (int c = 0; c < 3; c++)
          for (int f = 0; f < 2; f++) begin
            ins = mk(5'(bo), 5'(bi), 14'h3FF0 ^ 14'(bo * 7), 1'(bo & 1));
            apply_and_check(1'b1, 1'(f), ins, 32'hA000_0000 >> bi, (c == 2) ? 32'd0 : 32'(c + 1),
                            32'h0000_4000);
          end

    // R3: wrap from zero
    apply_and_check(1'b1, 1'b0, mk(5'b10000, 5'd0, 14'd0, 1'b0), 32'd0, 32'd0, 32'h10);
    chk("R3 wrap", ctr_next_o, 32'hFFFF_FFFF);

    // R2: selector n reads CR[31-n], high fields included
    for (int n = 0; n < 32; n++) begin
      apply_and_check(1'b1, 1'b0, mk(5'b01100, 5'(n), 14'd8, 1'b0), 32'h1 << (31 - n), 32'd5, 32'h200);
      chk("R2 select set", {31'd0, taken_o}, 32'd1);
      apply_and_check(1'b1, 1'b0, mk(5'b01100, 5'(n), 14'd8, 1'b0), ~(32'h1 << (31 - n)), 32'd5, 32'h200);
      chk("R2 select clear", {31'd0, taken_o}, 32'd0);
    end

    // Mnemonic cases in register-indirect form
    apply_and_check(1'b1, 1'b1, mk(5'b10100, 5'd3, 14'd0, 1'b0), 32'd0, 32'h1237, 32'h0);
    chk("R5 always", {31'd0, taken_o}, 32'd1);
    chk("R8 ind target", target_o, 32'h1234);
    apply_and_check(1'b1, 1'b1, mk(5'b01100, 5'd2, 14'd0, 1'b1), 32'h2000_0000, 32'h80, 32'h300);
    chk("R5 eq set", {31'd0, taken_o}, 32'd1);
    chk("R7 link", lr_val_o, 32'h304);
    apply_and_check(1'b1, 1'b1, mk(5'b00100, 5'd1, 14'd0, 1'b0), 32'h4000_0000, 32'h80, 32'h0);
    chk("R5 gt clear not taken", {31'd0, taken_o}, 32'd0);
    apply_and_check(1'b1, 1'b1, mk(5'b01101, 5'd7, 14'd0, 1'b0), 32'h0100_0000, 32'h80, 32'h0);
    chk("R6 so set hinted", {31'd0, taken_o & hint_o}, 32'd1);

    // R1 R6 R7 R8: random stimulus with a fixed seed
    void'($urandom(32'd1234));
    for (int k = 0; k < 600; k++)
      apply_and_check(1'($urandom % 8 != 0), 1'($urandom), $urandom, $urandom,
                      ($urandom % 4 == 0) ? 32'($urandom % 3) : $urandom, $urandom);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule